// File: doc/BRIEF.md
# Programmable Peripheral Clock Generator

This block produces a peripheral clock from one of three reference clocks. The references are not real clocks here. Each one arrives as a one-cycle enable pulse on a fast system clock, and each pulse stands for one cycle of that reference. A source multiplexer picks one reference. Two one-based dividers in series then lower its rate, and one or two output gates pass the divided clock through. Every output is also a pulse-and-level pair in the system clock domain. `out_clk` is the level of the derived clock. `out_tick` pulses once per derived period, in the cycle whose edge starts the next high phase.

Software sets up the block through a single-cycle write port and a combinational read port. The control word is at byte offset 0. It holds the source select in bits [5:4], the first divisor in [13:8] and the second divisor in [25:20]. Gate enables are in bits [1:0]. Software always reads back the value it last wrote. The divider chain and the gates run from a separate active copy of the word. That copy loads only when a derived period ends, or when every output is off, so retiming never produces a short phase.

The parameter `TWIN` adds a second gated output driven from the same divided clock. The parameter `FABRIC` moves gating to a separate register at byte offset 8, whose bit 0 stops the clock when set.

Top module: `pclk_gen`

## Requirements
- R1: After reset, the control word reads 0x0010_0100: select 0, both divisors 1, gates off. Only bits [25:20], [13:8], [5:4] and the implemented gate bits of [1:0] are stored; every other bit, and any other address, reads 0.
- R2: Select codes 0 and 1 both choose the I/O reference (`ref_io_tick`). Code 2 chooses the CPU reference (`ref_cpu_tick`). Code 3 chooses the memory reference (`ref_mem_tick`).
- R3: For divisor fields N0 (bits [13:8]) and N1 (bits [25:20]), the derived period is N0*N1 selected-reference cycles, and `out_tick` pulses once per period.
- R4: A divisor field of 0 behaves exactly like 1. The stage is bypassed and never hangs.
- R5: With N1 >= 2, `out_clk` is high for floor(N1/2) first-stage periods out of N1. With N1 <= 1 and N0 >= 2, it is high for floor(N0/2) reference cycles out of N0. Even divisors therefore give 50% duty, and odd divisors give a high phase one input cycle shorter than the low phase.
- R6: With both divisors 0 or 1, an enabled `out_clk` stays high, and `out_tick` follows every pulse of the selected reference.
- R7: Changing the select or divisor fields while an output runs takes effect only after the current derived period ends. That period keeps its old length.
- R8: Bit 0 gates output 0 (1 = running). Clearing it while the output runs lets the current period finish, including its last `out_tick`. After that, `out_clk[0]` and `out_tick[0]` stay 0.
- R9: With `TWIN`=1, bit 1 gates output 1 from the same divided clock, and the two outputs are identical when both are on. With `TWIN`=0, bit 1 reads 0 and output 1 stays 0.
- R10: With `FABRIC`=1, control bits [1:0] are ignored and read 0. A gate register at byte offset 8 controls output 0: bit 0 = 1 stops the clock, 0 runs it, and it resets to 1.
- R11: Turning on an output while all outputs are off starts a full period at once. The first sampled `out_clk` is high and the first period has its full length and full high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_io_tick | input | 1 | One pulse per I/O reference cycle |
| ref_cpu_tick | input | 1 | One pulse per CPU reference cycle |
| ref_mem_tick | input | 1 | One pulse per memory reference cycle |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | ADDR_W | Byte address: 0 control, 8 gate register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| out_clk | output | 2 | Derived clock levels, one per output |
| out_tick | output | 2 | One pulse per derived period, one per output |

## Verification
The bench measures the period and high-phase length over many select and divisor pairs. Zero divisors and odd divisors are included. A design that treats 0 as 64, drops the 0/1 alias, or rounds the odd high phase the wrong way gets a visibly wrong count.

It rewrites the divisors in mid-period and clears an enable in mid-period. A design that retimes at once shows a shortened period or a missing final pulse. It also turns a clock on from idle; a design that does not clear its counters first produces a runt first high phase.

A second instance covers the separate inverted gate register and checks that control-word enables are ignored there.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
    localparam int DATA_W   = 32;
    localparam int DIV_W    = 6;
    localparam int SRC_W    = 2;
    localparam int OUT_MAX  = 2;
    localparam int SRC_LSB  = 4;
    localparam int DIV0_LSB = 8;
    localparam int DIV1_LSB = 20;

    typedef struct packed {
        logic [SRC_W-1:0]   src;
        logic [DIV_W-1:0]   div0;
        logic [DIV_W-1:0]   div1;
        logic [OUT_MAX-1:0] gate;
    } pclk_cfg_t;

    typedef struct packed {
        pclk_cfg_t regs;     // software-visible copy
        logic      fab_off;  // separate stop bit (fabric variant)
        pclk_cfg_t act;      // copy driving the dividers and gates
    } pclk_state_t;

    localparam pclk_cfg_t CFG_RESET = '{src: '0, div0: DIV_W'(1),
                                        div1: DIV_W'(1), gate: '0};

    function automatic logic [DATA_W-1:0] pack_ctrl(pclk_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[SRC_LSB  +: SRC_W]   = c.src;
        w[DIV0_LSB +: DIV_W]   = c.div0;
        w[DIV1_LSB +: DIV_W]   = c.div1;
        w[0        +: OUT_MAX] = c.gate;
        return w;
    endfunction
endpackage

// File: rtl/pclk_src_mux.sv
module pclk_src_mux
    import pclk_pkg::*;
(
    input  logic [SRC_W-1:0] sel,
    input  logic             ref_io_tick,
    input  logic             ref_cpu_tick,
    input  logic             ref_mem_tick,
    output logic             tick
);
    // codes 0 and 1 alias onto the I/O reference
    always_comb begin
        case (sel)
            2'd2:    tick = ref_cpu_tick;
            2'd3:    tick = ref_mem_tick;
            default: tick = ref_io_tick;
        endcase
    end
endmodule

// File: rtl/pclk_div_stage.sv
module pclk_div_stage #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick_in,
    input  logic             lvl_in,
    input  logic [DIV_W-1:0] div,
    output logic             tick_out,
    output logic             lvl_out,
    output logic [DIV_W-1:0] cnt_o
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } stage_t;

    stage_t st_d, st_q;
    logic             bypass;
    logic [DIV_W-1:0] last;

    assign bypass = (div <= ONE);
    assign last   = div - ONE;
    assign cnt_o  = st_q.cnt;

    always_comb begin
        st_d     = st_q;
        tick_out = tick_in & (bypass | (st_q.cnt == last));
        lvl_out  = bypass ? lvl_in : (st_q.cnt < (div >> 1));
        if (clear || bypass) begin
            st_d.cnt = '0;
        end else if (tick_in) begin
            st_d.cnt = (st_q.cnt == last) ? '0 : st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pclk_out_gate.sv
module pclk_out_gate
    import pclk_pkg::*;
#(
    parameter int NUM_OUT = 2
) (
    input  logic [OUT_MAX-1:0] gate,
    input  logic               lvl,
    input  logic               tick,
    output logic [OUT_MAX-1:0] out_clk,
    output logic [OUT_MAX-1:0] out_tick
);
    logic unused_gate;
    assign unused_gate = ^gate;

    for (genvar i = 0; i < OUT_MAX; i++) begin : g_out
        if (i < NUM_OUT) begin : g_on
            assign out_clk[i]  = gate[i] & lvl;
            assign out_tick[i] = gate[i] & tick;
        end else begin : g_off
            assign out_clk[i]  = 1'b0;
            assign out_tick[i] = 1'b0;
        end
    end
endmodule

// File: rtl/pclk_gen.sv
module pclk_gen
    import pclk_pkg::*;
#(
    parameter int TWIN   = 1,
    parameter int FABRIC = 0,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_io_tick,
    input  logic              ref_cpu_tick,
    input  logic              ref_mem_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic [1:0]        out_clk,
    output logic [1:0]        out_tick
);
    localparam int NUM_OUT = (TWIN != 0 && FABRIC == 0) ? 2 : 1;
    localparam logic [OUT_MAX-1:0] EN_MASK =
        (FABRIC != 0) ? 2'b00 : ((NUM_OUT == 2) ? 2'b11 : 2'b01);
    localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] GATE_OFS = ADDR_W'(8);

    pclk_state_t st_d, st_q;

    pclk_cfg_t          act_cfg;
    logic               src_tick;
    logic               tick1, lvl1, tick2, lvl2;
    logic [DIV_W-1:0]   cnt0, cnt1;
    logic               idle, boundary;
    logic [OUT_MAX-1:0] eff_gate;
    logic               unused_wr;

    assign act_cfg   = st_q.act;
    assign idle      = (st_q.act.gate == '0);
    assign boundary  = tick2 & ~idle;
    assign eff_gate  = (FABRIC != 0) ? {{(OUT_MAX-1){1'b0}}, ~st_q.fab_off}
                                     : st_q.regs.gate;
    assign unused_wr = ^{wr_data[31:26], wr_data[19:14], wr_data[7:6],
                         wr_data[3:2]};

    pclk_src_mux u_mux (
        .sel          (st_q.act.src),
        .ref_io_tick  (ref_io_tick),
        .ref_cpu_tick (ref_cpu_tick),
        .ref_mem_tick (ref_mem_tick),
        .tick         (src_tick)
    );

    pclk_div_stage #(.DIV_W(DIV_W)) u_div0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (idle),
        .tick_in  (src_tick),
        .lvl_in   (1'b1),
        .div      (st_q.act.div0),
        .tick_out (tick1),
        .lvl_out  (lvl1),
        .cnt_o    (cnt0)
    );

    pclk_div_stage #(.DIV_W(DIV_W)) u_div1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (idle),
        .tick_in  (tick1),
        .lvl_in   (lvl1),
        .div      (st_q.act.div1),
        .tick_out (tick2),
        .lvl_out  (lvl2),
        .cnt_o    (cnt1)
    );

    pclk_out_gate #(.NUM_OUT(NUM_OUT)) u_gate (
        .gate     (st_q.act.gate),
        .lvl      (lvl2),
        .tick     (tick2),
        .out_clk  (out_clk),
        .out_tick (out_tick)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == CTRL_OFS) begin
            st_d.regs.src  = wr_data[SRC_LSB  +: SRC_W];
            st_d.regs.div0 = wr_data[DIV0_LSB +: DIV_W];
            st_d.regs.div1 = wr_data[DIV1_LSB +: DIV_W];
            st_d.regs.gate = wr_data[0 +: OUT_MAX] & EN_MASK;
        end
        if (FABRIC != 0 && wr_en && addr == GATE_OFS) begin
            st_d.fab_off = wr_data[0];
        end
        // retime only at the end of a derived period, or while all off
        if (idle || boundary) begin
            st_d.act      = st_q.regs;
            st_d.act.gate = eff_gate;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.regs    <= CFG_RESET;
            st_q.fab_off <= 1'b1;
            st_q.act     <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == CTRL_OFS) begin
            rd_data = pack_ctrl(st_q.regs);
        end else if (FABRIC != 0 && addr == GATE_OFS) begin
            rd_data[0] = st_q.fab_off;
        end
    end
endmodule

// File: rtl/pclk_gen_chk.sv
module pclk_gen_chk
    import pclk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ref_io_tick,
    input logic             ref_cpu_tick,
    input logic             ref_mem_tick,
    input logic [1:0]       out_clk,
    input logic [1:0]       out_tick,
    input pclk_cfg_t        act_cfg,
    input logic             boundary,
    input logic             idle,
    input logic [DIV_W-1:0] cnt0,
    input logic [DIV_W-1:0] cnt1
);
    // R2: a derived edge needs a reference pulse in the same cycle
    a_r2_tick_from_source: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tick != 2'b00) |-> (ref_io_tick || ref_cpu_tick || ref_mem_tick))
        else $error("a_r2_tick_from_source");

    // R7: the active configuration moves only at a period end or while idle
    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && !idle) |=> $stable(act_cfg))
        else $error("a_r7_cfg_hold");

    // R3 / R4: each stage counter stays inside its one-based range
    a_r3_cnt0_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.div0 <= DIV_W'(1)) ? (cnt0 == '0) : (cnt0 < act_cfg.div0))
        else $error("a_r3_cnt0_bound");

    a_r3_cnt1_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.div1 <= DIV_W'(1)) ? (cnt1 == '0) : (cnt1 < act_cfg.div1))
        else $error("a_r3_cnt1_bound");

    // R9: two enabled outputs carry the same clock
    a_r9_twin_match: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.gate == 2'b11) |-> (out_clk[0] == out_clk[1] &&
                                     out_tick[0] == out_tick[1]))
        else $error("a_r9_twin_match");
endmodule

bind pclk_gen pclk_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_io_tick  (ref_io_tick),
    .ref_cpu_tick (ref_cpu_tick),
    .ref_mem_tick (ref_mem_tick),
    .out_clk      (out_clk),
    .out_tick     (out_tick),
    .act_cfg      (act_cfg),
    .boundary     (boundary),
    .idle         (idle),
    .cnt0         (cnt0),
    .cnt1         (cnt1)
);

// File: tb/pclk_gen_tb.sv
module pclk_gen_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        rst_n = 1'b0;
    logic        ref_io = 1'b0, ref_cpu = 1'b0, ref_mem = 1'b0;
    logic        wr_en = 1'b0, f_wr_en = 1'b0;
    logic [3:0]  addr = '0, f_addr = '0;
    logic [31:0] wr_data = '0, f_wr_data = '0;
    logic [31:0] rd_data, f_rd_data;
    logic [1:0]  out_clk, out_tick, f_out_clk, f_out_tick;

    pclk_gen u_dut (
        .clk(clk), .rst_n(rst_n), .ref_io_tick(ref_io), .ref_cpu_tick(ref_cpu),
        .ref_mem_tick(ref_mem), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .out_clk(out_clk), .out_tick(out_tick));

    pclk_gen #(.TWIN(0), .FABRIC(1)) u_fab (
        .clk(clk), .rst_n(rst_n), .ref_io_tick(ref_io), .ref_cpu_tick(ref_cpu),
        .ref_mem_tick(ref_mem), .wr_en(f_wr_en), .addr(f_addr),
        .wr_data(f_wr_data), .rd_data(f_rd_data), .out_clk(f_out_clk),
        .out_tick(f_out_tick));

    int n_checks = 0, n_err = 0, cyc = 0;
    logic        p_wr = 0, pf_wr = 0;
    logic [3:0]  p_addr = 0, pf_addr = 0;
    logic [31:0] p_data = 0, pf_data = 0;
    logic [1:0]  s_clk, s_tick, sf_clk, sf_tick;
    logic [31:0] s_rd, sf_rd;

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     tag, act, act, exp, exp);
        end
    endtask

    // one system cycle: drive just after the falling edge, sample before the rising one
    task automatic step();
        @(negedge clk);
        ref_io    = 1'b1;
        ref_cpu   = (cyc % 2 == 0);
        ref_mem   = (cyc % 3 == 0);
        cyc++;
        wr_en     = p_wr;  addr   = p_addr;  wr_data   = p_data;
        f_wr_en   = pf_wr; f_addr = pf_addr; f_wr_data = pf_data;
        p_wr = 0; pf_wr = 0;
        #3;
        s_clk = out_clk;   s_tick = out_tick;   s_rd = rd_data;
        sf_clk = f_out_clk; sf_tick = f_out_tick; sf_rd = f_rd_data;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        p_wr = 1; p_addr = a; p_data = d; step();
    endtask
    task automatic fwr(input logic [3:0] a, input logic [31:0] d);
        pf_wr = 1; pf_addr = a; pf_data = d; step();
    endtask
    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        p_addr = a; step(); chk(s_rd == e, tag, s_rd, e);
    endtask
    task automatic frd(input logic [3:0] a, input logic [31:0] e, input string tag);
        pf_addr = a; step(); chk(sf_rd == e, tag, sf_rd, e);
    endtask

    function automatic logic tk(int w);
        return (w == 0) ? s_tick[0] : (w == 1) ? s_tick[1] : sf_tick[0];
    endfunction
    function automatic logic lv(int w);
        return (w == 0) ? s_clk[0] : (w == 1) ? s_clk[1] : sf_clk[0];
    endfunction

    function automatic logic [31:0] cfg(int src, int n0, int n1, int en);
        return (32'(n1) << 20) | (32'(n0) << 8) | (32'(src) << 4) | 32'(en);
    endfunction
    function automatic int spacing(int src);
        return (src == 2) ? 2 : (src == 3) ? 3 : 1;
    endfunction
    function automatic int exp_per(int src, int n0, int n1);
        return ((n0 < 1) ? 1 : n0) * ((n1 < 1) ? 1 : n1) * spacing(src);
    endfunction
    function automatic int exp_hi(int src, int n0, int n1);
        if (n1 >= 2) return (n1 / 2) * ((n0 < 1) ? 1 : n0) * spacing(src);
        if (n0 >= 2) return (n0 / 2) * spacing(src);
        return spacing(src);
    endfunction

    task automatic sync_tick(int w, string tag);
        int t = 0;
        do begin step(); t++; end while (!tk(w) && t < 20000);
        if (t >= 20000) chk(0, tag, t, 0);
    endtask

    // mode 1: outputs 0 and 1 must match; mode 2: the other main output must stay silent
    task automatic measure(int w, int pe, int he, int mode, string tag);
        int per = 0, hi = 0, bad = 0;
        do begin
            step(); per++;
            if (lv(w)) hi++;
            if (mode == 1 && s_clk != {s_clk[0], s_clk[0]}) bad++;
            if (mode == 2 && (s_clk[1-w] || s_tick[1-w])) bad++;
        end while (!tk(w) && per < 20000);
        chk(per == pe, {tag, " period"}, per, pe);
        chk(hi == he, {tag, " high"}, hi, he);
        if (mode != 0) chk(bad == 0, {tag, " other output"}, bad, 0);
    endtask

    task automatic run_cfg(int src, int n0, int n1, int en, int mode, string tag);
        int w = (en == 2) ? 1 : 0;
        wr(4'd0, cfg(src, n0, n1, en));
        sync_tick(w, tag);
        sync_tick(w, tag);
        measure(w, exp_per(src, n0, n1), exp_hi(src, n0, n1), mode, tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int seed;
        int t;
        seed = $urandom(32'h5eed_c10c);
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state and field storage
        chk(s_clk == 0 && s_tick == 0, "R1 outputs off after reset", s_clk, 0);
        rd(4'd0, 32'h0010_0100, "R1 reset control word");
        wr(4'd0, 32'hFFFF_FFFC);
        rd(4'd0, 32'h03F0_3F30, "R1 stored field mask");
        wr(4'd0, 32'h0000_0000);
        rd(4'd0, 32'h0000_0000, "R1 zero readback");
        rd(4'd4, 32'h0000_0000, "R1 unmapped address");
        wr(4'd0, 32'h0000_0003);
        rd(4'd0, 32'h0000_0003, "R1 R9 gate bits stored");

        // R6: both stages bypassed
        run_cfg(0, 0, 0, 3, 1, "R6 bypass io");
        run_cfg(3, 1, 0, 3, 1, "R6 bypass mem");

        // R2: each select code
        run_cfg(0, 2, 2, 1, 0, "R2 code0 io");
        run_cfg(1, 2, 2, 1, 0, "R2 code1 io alias");
        run_cfg(2, 2, 2, 1, 0, "R2 code2 cpu");
        run_cfg(3, 2, 2, 1, 0, "R2 code3 mem");

        // R4 / R5: zero divisors and odd divisors
        run_cfg(0, 0, 3, 1, 0, "R4 div0 zero");
        run_cfg(2, 4, 0, 1, 0, "R4 div1 zero");
        run_cfg(0, 5, 1, 1, 0, "R5 odd first stage");
        run_cfg(0, 2, 7, 1, 0, "R5 odd second stage");
        run_cfg(0, 63, 63, 1, 0, "R3 R5 max divisors");

        // R3: constrained random pairs, twin outputs compared
        for (int i = 0; i < 24; i++) begin
            int src = $urandom % 4;
            int n0 = $urandom % 6;
            int n1 = $urandom % 6;
            run_cfg(src, n0, n1, 3, 1, "R3 random");
        end

        // R7: a divisor change in mid-period waits for the period end
        run_cfg(0, 10, 10, 1, 0, "R7 setup");
        t = 0;
        repeat (30) begin step(); t++; end
        wr(4'd0, cfg(0, 3, 1, 1)); t++;
        while (!s_tick[0] && t < 20000) begin step(); t++; end
        chk(t == 100, "R7 old period kept", t, 100);
        measure(0, 3, 1, 0, "R7 new period");

        // R8: clearing the enable in mid-period
        run_cfg(0, 4, 5, 1, 0, "R8 setup");
        repeat (5) step();
        wr(4'd0, cfg(0, 4, 5, 0));
        begin
            int ticks = 0, hi_after = 0;
            repeat (200) begin
                step();
                if (s_tick[0]) ticks++;
                else if (ticks > 0 && s_clk[0]) hi_after++;
            end
            chk(ticks == 1, "R8 final period completes", ticks, 1);
            chk(hi_after == 0, "R8 silent after disable", hi_after, 0);
        end

        // R11: start from idle gives a full first period
        wr(4'd0, cfg(0, 6, 4, 1));
        t = 0;
        while (!s_clk[0] && t < 100) begin step(); t++; end
        chk(t < 100, "R11 output starts", t, 0);
        begin
            int per = 1, hi = 1;
            while (!s_tick[0] && per < 20000) begin
                step(); per++;
                if (s_clk[0]) hi++;
            end
            chk(per == 24, "R11 first period length", per, 24);
            chk(hi == 12, "R11 first high phase", hi, 12);
        end

        // R9: outputs gated independently
        run_cfg(0, 2, 2, 1, 2, "R9 only output0");
        run_cfg(0, 2, 2, 2, 2, "R9 only output1");

        // R10: separate inverted gate register
        frd(4'd8, 32'h0000_0001, "R10 gate reset stopped");
        frd(4'd0, 32'h0010_0100, "R10 R1 reset control word");
        fwr(4'd0, 32'h0010_0203);
        frd(4'd0, 32'h0010_0200, "R10 control enables ignored");
        begin
            int act = 0;
            repeat (50) begin step(); if (sf_tick[0] || sf_clk[0]) act++; end
            chk(act == 0, "R10 still stopped", act, 0);
        end
        chk(sf_clk[1] == 0 && sf_tick[1] == 0, "R9 second output absent", sf_clk[1], 0);
        fwr(4'd8, 32'h0000_0000);
        sync_tick(2, "R10 run");
        sync_tick(2, "R10 run");
        measure(2, 2, 1, 0, "R10 running");
        fwr(4'd8, 32'h0000_0001);
        repeat (10) step();
        begin
            int act = 0;
            repeat (40) begin step(); if (sf_tick[0] || sf_clk[0]) act++; end
            chk(act == 0, "R10 stopped by gate bit", act, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule